// File: doc/BRIEF.md
# Page Write Commit and Protection Controller

This block sits behind a two-wire serial slave engine in an electrically erasable byte memory. The engine reports each received byte as a one-cycle event: a device select (memory or protection-register type, read or write), an address byte or a data byte. For each event, one cycle later, the block gives an acknowledge decision. Accepted data bytes are gathered into a row buffer whose slot index is the low four address bits. The row number, held in the upper address bits, never changes within a sequence.

The engine also sends a commit pulse when a STOP arrives in the slot right after an acknowledge, and an abort pulse for a STOP anywhere else. A commit starts a timed busy interval. During that interval the buffered row is written to the array, one strobe per accepted slot in ascending slot order. While busy, the block refuses every select and byte. A write-control pin blocks all writes. A one-time lock, set by a completed write to the protection register, protects the lower half of the address space for good. The lock cell is cleared only by a factory/power-model input, never by the ordinary reset.

States: `ST_IDLE` (no write sequence), `ST_WADDR` (memory write selected, address byte awaited), `ST_WDATA` (collecting memory data), `ST_PADDR` (protection write selected, address byte awaited), `ST_PDATA` (collecting protection data), `ST_BUSY` (timed commit). Transitions:
- Any non-busy state goes to `ST_WADDR`, `ST_PADDR` or `ST_IDLE` on a select, depending on type, direction and lock.
- `ST_WADDR` goes to `ST_WDATA` on an address byte, and `ST_PADDR` goes to `ST_PDATA` on an address byte.
- `ST_WDATA` or `ST_PDATA` goes to `ST_BUSY` on commit when something is pending. Otherwise commit goes to `ST_IDLE`.
- Abort goes to `ST_IDLE`.
- `ST_BUSY` goes to `ST_IDLE` when the timer expires.

Top module: `page_commit_guard`

## Requirements
- R1: A memory-type select (`sel_prot`=0) gets `ack`=1 one cycle later whenever the block is not busy, for read or write and whatever the level of `wc`.
- R2: A protection-type select (`sel_prot`=1), read or write, gets `ack`=1 while `locked`=0 and `ack`=0 once `locked`=1.
- R3: Every select, address or data event produces exactly one `ack_valid` pulse in the following cycle. An address byte after a write select is acknowledged. A memory data byte is acknowledged only when `wc`=0 and the current address is not protected.
- R4: The address byte loads row = bits 7..4 and slot = bits 3..0. Each data byte advances the slot by one modulo 16 while the row stays fixed. A later byte to the same slot replaces the earlier one.
- R5: An abort, or a commit with no accepted data pending, ends the sequence without entering busy and without any `mem_we`.
- R6: A commit with pending data raises `busy` in the next cycle for exactly BUSY_CYCLES cycles. `mem_we` fires once per accepted slot, in ascending slot order, with `mem_addr` = {row, slot}. Slots never written keep their old array contents (no strobe).
- R7: With `wc`=1, data bytes get `ack`=0, nothing is written, and a protection-register write does not set the lock.
- R8: A protection-register write with `wc`=0 and an acknowledged data byte, followed by a commit, sets `locked` when the busy interval ends. Its address and data values are don't-care, and it produces no `mem_we`.
- R9: With `locked`=1, data bytes to addresses 00h..7Fh get `ack`=0 and are not written. Addresses 80h..FFh stay writable with `wc`=0.
- R10: After reset `busy`, `ack_valid` and `mem_we` are 0. `locked` starts at 0 after `factory_n` is asserted, survives `rst_n`, and is cleared only by `factory_n`.
- R11: While busy, selects, address and data bytes all get `ack`=0, and commit and abort pulses have no effect on the busy length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the control logic |
| factory_n | input | 1 | Active-low clear of the non-volatile lock (power/factory model only) |
| wc | input | 1 | Write control pin, 1 blocks writes |
| ev_sel | input | 1 | Pulse: device select byte received |
| sel_prot | input | 1 | With ev_sel: 1 = protection-register type |
| sel_rd | input | 1 | With ev_sel: 1 = read direction |
| ev_addr | input | 1 | Pulse: address byte received |
| ev_data | input | 1 | Pulse: data byte received |
| ev_byte | input | 8 | Byte value for ev_addr / ev_data |
| ev_stop_ok | input | 1 | Pulse: STOP in the slot right after an acknowledge (commit) |
| ev_abort | input | 1 | Pulse: STOP at any other point (discard) |
| ack_valid | output | 1 | Decision strobe, one cycle after an event |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| busy | output | 1 | Commit interval in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| locked | output | 1 | Lower half permanently protected |

## Verification
A wrong slot counter or row register shows up as a `mem_addr` mismatch on the first strobe of the commit. That comes at most 16 cycles after the commit pulse. A stale valid bit shows as an extra or missing strobe in the same window. A wrong state shows up the next time a byte arrives: the decision one cycle after the event carries the wrong `ack`. A lock that is set too early, set wrongly or lost is caught by the next protection-type select or the next lower-half data byte, both of which are decided in one cycle. Timer faults change the measured `busy` length of the very next commit.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDATA,
        ST_PADDR,
        ST_PDATA,
        ST_BUSY
    } pcg_state_e;
endpackage

// File: rtl/pcg_row_buf.sv
module pcg_row_buf #(
    parameter int ROW_BYTES = 16,
    parameter int DATA_W    = 8,
    localparam int OFS_W    = $clog2(ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [ROW_BYTES-1:0] vld_vec;
    logic [DATA_W-1:0]    data_arr [ROW_BYTES];

    for (genvar i = 0; i < ROW_BYTES; i++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '1;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr && wr_idx == OFS_W'(i)) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end
        end
        assign vld_vec[i]  = v_q;
        assign data_arr[i] = d_q;
    end

    assign rd_data   = data_arr[rd_idx];
    assign rd_valid  = vld_vec[rd_idx];
    assign any_valid = |vld_vec;
endmodule

// File: rtl/pcg_busy_timer.sv
module pcg_busy_timer #(
    parameter int BUSY_CYCLES = 40,
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    assign done = run && (cnt == CNT_W'(BUSY_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || done) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcg_lock_cell.sv
module pcg_lock_cell (
    input  logic clk,
    input  logic factory_n,
    input  logic set,
    output logic locked
);
    // Models non-volatile storage: the ordinary reset does not reach it.
    always_ff @(posedge clk or negedge factory_n) begin
        if (!factory_n) locked <= 1'b0;
        else if (set)   locked <= 1'b1;
    end
endmodule

// File: rtl/page_commit_guard.sv
module page_commit_guard
    import pcg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int ROW_BYTES   = 16,
    parameter int BUSY_CYCLES = 40   // must be >= ROW_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              factory_n,
    input  logic              wc,
    input  logic              ev_sel,
    input  logic              sel_prot,
    input  logic              sel_rd,
    input  logic              ev_addr,
    input  logic              ev_data,
    input  logic [DATA_W-1:0] ev_byte,
    input  logic              ev_stop_ok,
    input  logic              ev_abort,
    output logic              ack_valid,
    output logic              ack,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              locked
);
    localparam int OFS_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - OFS_W;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    pcg_state_e state_q, state_nx;

    logic [ROW_W-1:0] row_q;
    logic [OFS_W-1:0] ofs_q;
    logic             arm_q;
    logic             ack_v_q, ack_q;

    logic             dec_v, dec_ack;
    logic             buf_wr, buf_clr, ofs_load, ofs_inc, arm_set, lock_set;
    logic             any_valid, rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0] cnt;
    logic             t_done, run;
    logic             low_half, data_ok;

    assign run      = (state_q == ST_BUSY);
    assign low_half = ~row_q[ROW_W-1];
    assign data_ok  = !wc && !(locked && low_half);

    pcg_row_buf #(.ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .wr_idx(ofs_q), .wr_data(ev_byte), .rd_idx(cnt[OFS_W-1:0]),
        .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
    );

    pcg_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .done(t_done)
    );

    pcg_lock_cell u_lock (
        .clk(clk), .factory_n(factory_n), .set(lock_set), .locked(locked)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BUSY: if (t_done) state_nx = ST_IDLE;
            ST_IDLE, ST_WADDR, ST_WDATA, ST_PADDR, ST_PDATA: begin
                if (ev_sel) begin
                    if (sel_rd)        state_nx = ST_IDLE;
                    else if (!sel_prot) state_nx = ST_WADDR;
                    else if (!locked)  state_nx = ST_PADDR;
                    else               state_nx = ST_IDLE;
                end else if (ev_addr) begin
                    if (state_q == ST_WADDR)      state_nx = ST_WDATA;
                    else if (state_q == ST_PADDR) state_nx = ST_PDATA;
                end else if (ev_stop_ok) begin
                    if ((state_q == ST_WDATA && any_valid) ||
                        (state_q == ST_PDATA && arm_q))
                        state_nx = ST_BUSY;
                    else
                        state_nx = ST_IDLE;
                end else if (ev_abort) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        dec_v    = ev_sel || ev_addr || ev_data;
        dec_ack  = 1'b0;
        buf_wr   = 1'b0;
        buf_clr  = 1'b0;
        ofs_load = 1'b0;
        ofs_inc  = 1'b0;
        arm_set  = 1'b0;
        lock_set = 1'b0;
        unique case (state_q)
            ST_BUSY: begin
                if (t_done) begin
                    buf_clr  = 1'b1;
                    lock_set = arm_q;
                end
            end
            ST_IDLE, ST_WADDR, ST_WDATA, ST_PADDR, ST_PDATA: begin
                if (ev_sel) begin
                    dec_ack = !(sel_prot && locked);
                    buf_clr = 1'b1;
                end else if (ev_addr) begin
                    if (state_q == ST_WADDR || state_q == ST_PADDR) begin
                        dec_ack  = 1'b1;
                        ofs_load = 1'b1;
                    end
                end else if (ev_data) begin
                    if (state_q == ST_WDATA) begin
                        dec_ack = data_ok;
                        buf_wr  = data_ok;
                        ofs_inc = 1'b1;
                    end else if (state_q == ST_PDATA) begin
                        dec_ack = !wc;
                        arm_set = !wc;
                    end
                end else if (ev_stop_ok) begin
                    if (!((state_q == ST_WDATA && any_valid) ||
                          (state_q == ST_PDATA && arm_q)))
                        buf_clr = 1'b1;
                end else if (ev_abort) begin
                    buf_clr = 1'b1;
                end
            end
            default: buf_clr = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            ofs_q   <= '0;
            arm_q   <= 1'b0;
            ack_v_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ack_v_q <= dec_v;
            ack_q   <= dec_v && dec_ack;
            if (ofs_load) begin
                row_q <= ev_byte[ADDR_W-1:OFS_W];
                ofs_q <= ev_byte[OFS_W-1:0];
            end else if (ofs_inc) begin
                ofs_q <= ofs_q + 1'b1;
            end
            if (buf_clr)      arm_q <= 1'b0;
            else if (arm_set) arm_q <= 1'b1;
        end
    end

    assign ack_valid = ack_v_q;
    assign ack       = ack_q;
    assign busy      = run;
    assign mem_we    = run && (cnt < CNT_W'(ROW_BYTES)) && rd_valid;
    assign mem_addr  = {row_q, cnt[OFS_W-1:0]};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/pcg_check.sv
module pcg_check #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              factory_n,
    input logic              wc,
    input logic              ev_sel,
    input logic              sel_prot,
    input logic              ev_addr,
    input logic              ev_data,
    input logic              busy,
    input logic              ack_valid,
    input logic              ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              locked
);
    p_busy_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (ev_sel || ev_addr || ev_data) |=> ack_valid && !ack);

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!factory_n)
        locked |=> locked);

    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_prot_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked && ev_sel && sel_prot |=> ack_valid && !ack);

    p_low_half_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && locked |-> mem_addr[ADDR_W-1]);

    p_wc_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data && wc |=> ack_valid && !ack);

    p_one_decision_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sel || ev_addr || ev_data) |=> ack_valid);
endmodule

bind page_commit_guard pcg_check #(.ADDR_W(ADDR_W)) u_pcg_check (
    .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .wc(wc),
    .ev_sel(ev_sel), .sel_prot(sel_prot), .ev_addr(ev_addr), .ev_data(ev_data),
    .busy(busy), .ack_valid(ack_valid), .ack(ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .locked(locked)
);

// File: tb/test_page_commit_guard.sv
module test_page_commit_guard;
    localparam int BUSY = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, factory_n, wc, ev_sel, sel_prot, sel_rd, ev_addr, ev_data;
    logic ev_stop_ok, ev_abort;
    logic [7:0] ev_byte;
    logic ack_valid, ack, busy, mem_we, locked;
    logic [7:0] mem_addr, mem_wdata;

    page_commit_guard #(.BUSY_CYCLES(BUSY)) i_page_commit_guard (
        .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .wc(wc),
        .ev_sel(ev_sel), .sel_prot(sel_prot), .sel_rd(sel_rd),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_byte(ev_byte),
        .ev_stop_ok(ev_stop_ok), .ev_abort(ev_abort),
        .ack_valid(ack_valid), .ack(ack), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .locked(locked)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic        exp_ack_q [$];
    string       exp_tag_q [$];
    logic [15:0] exp_w_q   [$];
    int          busy_run  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compares design results against the scoreboard queues
    logic        m_e;
    string       m_t;
    logic [15:0] m_w;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin
                if (exp_ack_q.size() == 0) begin
                    check(1'b0, "R3 unexpected decision", ack, 0);
                end else begin
                    m_e = exp_ack_q.pop_front();
                    m_t = exp_tag_q.pop_front();
                    check(ack == m_e, m_t, ack, m_e);
                end
            end
            if (mem_we) begin
                if (exp_w_q.size() == 0) begin
                    check(1'b0, "R6 unexpected array write", {mem_addr, mem_wdata}, 0);
                end else begin
                    m_w = exp_w_q.pop_front();
                    check({mem_addr, mem_wdata} == m_w, "R6 write addr/data",
                          {mem_addr, mem_wdata}, m_w);
                end
            end
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                check(busy_run == BUSY, "R6 busy length", busy_run, BUSY);
                busy_run = 0;
            end
        end
    end

    // Driver tasks: each pushes its expected decision
    task automatic do_sel(input logic prot, input logic rd, input logic exp, input string tag);
        @(negedge clk);
        ev_sel = 1'b1; sel_prot = prot; sel_rd = rd;
        exp_ack_q.push_back(exp); exp_tag_q.push_back(tag);
        @(negedge clk);
        ev_sel = 1'b0; sel_prot = 1'b0; sel_rd = 1'b0;
    endtask

    task automatic do_byte(input bit is_addr, input logic [7:0] b, input logic exp, input string tag);
        @(negedge clk);
        ev_addr = is_addr; ev_data = !is_addr; ev_byte = b;
        exp_ack_q.push_back(exp); exp_tag_q.push_back(tag);
        @(negedge clk);
        ev_addr = 1'b0; ev_data = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop_ok = 1'b1;
        @(negedge clk); ev_stop_ok = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk); ev_abort = 1'b1;
        @(negedge clk); ev_abort = 1'b0;
    endtask

    task automatic exp_w(input logic [7:0] a, input logic [7:0] d);
        exp_w_q.push_back({a, d});
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 0; factory_n = 0; wc = 0; ev_sel = 0; sel_prot = 0; sel_rd = 0;
        ev_addr = 0; ev_data = 0; ev_byte = 0; ev_stop_ok = 0; ev_abort = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; factory_n = 1;
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && ack_valid == 0 && mem_we == 0, "R10 reset outputs",
              {busy, ack_valid, mem_we}, 0);
        check(locked == 0, "R10 lock after factory clear", locked, 0);

        // R1, R3, R6: plain page write from 35h
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h35, 1, "R3 address ack");
        for (int i = 0; i < 3; i++) do_byte(0, 8'hA0 + 8'(i), 1, "R3 data ack");
        exp_w(8'h35, 8'hA0); exp_w(8'h36, 8'hA1); exp_w(8'h37, 8'hA2);
        do_stop();
        check(busy == 1, "R6 busy after commit", busy, 1);
        wait_idle();

        // R4: wrap inside row 4x
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h4E, 1, "R3 address ack");
        for (int i = 0; i < 5; i++) do_byte(0, 8'hB0 + 8'(i), 1, "R4 data ack");
        exp_w(8'h40, 8'hB2); exp_w(8'h41, 8'hB3); exp_w(8'h42, 8'hB4);
        exp_w(8'h4E, 8'hB0); exp_w(8'h4F, 8'hB1);
        do_stop();
        // R11: everything refused while busy, stop/abort ignored
        do_sel(0, 0, 0, "R11 select while busy");
        do_sel(0, 1, 0, "R11 read select while busy");
        do_byte(0, 8'h77, 0, "R11 data while busy");
        do_stop();
        do_abort();
        check(busy == 1, "R11 still busy", busy, 1);
        wait_idle();

        // R4: 17 bytes, slot 0 overwritten
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h60, 1, "R3 address ack");
        for (int i = 0; i < 17; i++) do_byte(0, 8'hC0 + 8'(i), 1, "R4 data ack");
        exp_w(8'h60, 8'hD0);
        for (int i = 1; i < 16; i++) exp_w(8'h60 + 8'(i), 8'hC0 + 8'(i));
        do_stop();
        wait_idle();

        // R5: abort discards, empty commit does nothing
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h10, 1, "R3 address ack");
        do_byte(0, 8'hD5, 1, "R3 data ack");
        do_abort();
        do_stop();
        check(busy == 0, "R5 abort then stop no busy", busy, 0);
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h20, 1, "R3 address ack");
        do_stop();
        check(busy == 0, "R5 empty commit no busy", busy, 0);

        // R7: write control high
        wc = 1;
        do_sel(0, 0, 1, "R1 select with wc high");
        do_byte(1, 8'h90, 1, "R3 address ack");
        do_byte(0, 8'h11, 0, "R7 data nack wc");
        do_byte(0, 8'h12, 0, "R7 data nack wc");
        do_stop();
        check(busy == 0, "R7 no commit wc", busy, 0);
        do_sel(1, 0, 1, "R2 prot select unlocked");
        do_byte(1, 8'h00, 1, "R3 prot address ack");
        do_byte(0, 8'h00, 0, "R7 prot data nack wc");
        do_stop();
        check(busy == 0 && locked == 0, "R7 lock not set", {busy, locked}, 0);
        wc = 0;
        do_sel(1, 1, 1, "R2 prot read select unlocked");

        // R8: set the lock
        do_sel(1, 0, 1, "R2 prot write select");
        do_byte(1, 8'h3C, 1, "R8 prot address don't-care");
        do_byte(0, 8'h5A, 1, "R8 prot data don't-care");
        do_stop();
        check(busy == 1 && locked == 0, "R8 busy, lock pending", {busy, locked}, 2);
        wait_idle();
        check(locked == 1, "R8 lock set", locked, 1);

        // R2, R9: locked behaviour
        do_sel(1, 0, 0, "R2 prot write select locked");
        do_sel(1, 1, 0, "R2 prot read select locked");
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h7F, 1, "R3 address ack");
        do_byte(0, 8'h11, 0, "R9 low half nack");
        do_byte(0, 8'h22, 0, "R9 low half nack after wrap");
        do_stop();
        check(busy == 0, "R9 no commit low half", busy, 0);
        do_sel(0, 0, 1, "R1 mem write select");
        do_byte(1, 8'h85, 1, "R3 address ack");
        do_byte(0, 8'hE0, 1, "R9 upper half ack");
        exp_w(8'h85, 8'hE0);
        do_stop();
        wait_idle();

        // R10: lock survives reset, cleared by factory input
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(locked == 1, "R10 lock survives reset", locked, 1);
        factory_n = 0;
        @(negedge clk); factory_n = 1;
        @(negedge clk);
        check(locked == 0, "R10 factory clear", locked, 0);
        do_sel(1, 0, 1, "R2 prot select after factory clear");

        repeat (3) @(negedge clk);
        check(exp_ack_q.size() == 0, "R3 decisions outstanding", exp_ack_q.size(), 0);
        check(exp_w_q.size() == 0, "R6 writes outstanding", exp_w_q.size(), 0);
        finish_run();
    end
endmodule